// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects event pulses from seven peripheral groups and turns them into one active-low interrupt line for a host. Each group owns a small set of secondary interrupt bits. A bit latches on the rising edge of its event input and stays set until the host clears it by writing 1. Every group also has a secondary mask. A group's primary bit is the OR of its secondary bits that are set and not masked. Primary bits are read-only.

A second layer of masks, one per primary, decides which primaries may pull the interrupt line low. These masks do not change what the primary status register reads. All masks come out of reset set, so nothing reaches the host until software opens the path.

The host accesses the block through a simple parallel register port, with one address, a write strobe, write data and combinational read data. The expected service flow has four steps:

1. See the line go low.
2. Read the primary status register.
3. Read the secondary status of the flagged groups.
4. Clear the serviced bits by writing 1.

Top module: `irq_aggregator`

## Requirements
- R1: A secondary bit is set one clock after its event input is sampled high, having been sampled low the cycle before (a rising edge). An event input held high sets its bit only once. A bit never sets without such an edge.
- R2: Writing the secondary status register of a group clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: A rising event in the same cycle as a write-1 clear of that bit leaves the bit set.
- R4: A group's primary bit reads 1 while at least one secondary bit of that group is set with its secondary mask bit at 0. The groups map to primary status bits as follows: group 0 at bit 15, group 1 at 14, group 2 at 13, group 3 at 12, group 4 at 11, group 5 at 10 and group 6 at 9.
- R5: A primary bit returns to 0 only when every secondary bit of its group is cleared or masked. Masking the set bits drops it while the secondary status bits remain readable as set.
- R6: The primary status reads the same whether its primary mask bit is 0 or 1.
- R7: irq_n is registered. It is 0 in the cycle after any primary bit is 1 with its primary mask bit 0, and it is 1 otherwise. A primary with its mask bit 1 never drives irq_n low.
- R8: After reset, every primary mask bit and every secondary mask bit is 1, every status bit is 0, and irq_n is 1.
- R9: The register map is as follows:
  - Primary status is at 0x4010 and is read-only; writes to it have no effect.
  - Primary mask is at 0x4018, using bits 15..9 in the same group order as R4.
  - Secondary status of group g is at 0x4020+g.
  - Secondary mask of group g is at 0x4030+g.
  - Both secondary registers use data bits 3..0 for event inputs 0..3 of the group.
  - Unused bits read 0 and ignore writes, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 28 | Event inputs; group g uses bits 4g+3..4g |
| reg_addr | input | 16 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The bench sweeps every group and every secondary bit and predicts each register from a small arithmetic model. It targets four corner cases:

- **Event colliding with a write-1 clear.** A design where the clear wins would lose an event.
- **Event held high across a clear.** A level-sensitive latch would set the bit again at once.
- **Primary derivation under masking.** It checks that a primary falls only when its last unmasked secondary goes away. It also checks that a primary still reads set while its primary mask is 1, but does not touch irq_n.
- **Map edges.** These are writes to the read-only primary register, out-of-field write bits and unmapped addresses. A loose decode would corrupt masks or return stray data there.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned DEF_NUM_GROUPS = 7;
    localparam int unsigned DEF_EVT_W      = 4;
    localparam int unsigned DEF_ADDR_W     = 16;
    localparam int unsigned DEF_DATA_W     = 16;

    localparam logic [DEF_ADDR_W-1:0] DEF_PRIM_STAT_ADDR = 16'h4010;
    localparam logic [DEF_ADDR_W-1:0] DEF_PRIM_MASK_ADDR = 16'h4018;
    localparam logic [DEF_ADDR_W-1:0] DEF_SEC_STAT_BASE  = 16'h4020;
    localparam logic [DEF_ADDR_W-1:0] DEF_SEC_MASK_BASE  = 16'h4030;

    // Primary bit position of a group: group 0 sits at the top bit.
    function automatic int unsigned prim_pos(int unsigned data_w, int unsigned grp);
        return data_w - 1 - grp;
    endfunction

endpackage

// File: rtl/irq_sec_group.sv
module irq_sec_group #(
    parameter int unsigned EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             stat_wr_i,
    input  logic             mask_wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [EVT_W-1:0] stat_o,
    output logic [EVT_W-1:0] mask_o,
    output logic             pend_o
);

    typedef struct packed {
        logic [EVT_W-1:0] ev_last;
        logic [EVT_W-1:0] stat;
        logic [EVT_W-1:0] mask;
    } grp_state_t;

    grp_state_t       st_d, st_q;
    logic [EVT_W-1:0] rise;
    logic [EVT_W-1:0] clr;

    always_comb begin
        rise        = evt_i & ~st_q.ev_last;
        clr         = stat_wr_i ? wdata_i : '0;
        st_d        = st_q;
        st_d.ev_last = evt_i;
        // a fresh edge overrides a simultaneous clear
        st_d.stat   = (st_q.stat & ~clr) | rise;
        if (mask_wr_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ev_last <= '0;
            st_q.stat    <= '0;
            st_q.mask    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign pend_o = |(st_q.stat & ~st_q.mask);

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.stat & $past(rise)) == $past(rise))); // R1

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & ~$past(st_q.stat) & ~$past(rise)) == '0)); // R1

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i |=> ((st_q.stat & $past(wdata_i & ~rise)) == '0)); // R2

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & clr) != '0) |=> ((st_q.stat & $past(rise & clr)) == $past(rise & clr))); // R3

endmodule

// File: rtl/irq_prim_ctrl.sv
module irq_prim_ctrl #(
    parameter int unsigned NUM_GROUPS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] pend_i,
    input  logic                  mask_wr_i,
    input  logic [NUM_GROUPS-1:0] mask_wdata_i,
    output logic [NUM_GROUPS-1:0] pmask_o,
    output logic                  irq_n_o
);

    typedef struct packed {
        logic [NUM_GROUPS-1:0] pmask;
        logic                  irq_n;
    } prim_state_t;

    prim_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~|(pend_i & ~st_q.pmask);
        if (mask_wr_i) begin
            st_d.pmask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pmask <= '1;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pmask_o = st_q.pmask;
    assign irq_n_o = st_q.irq_n;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~pmask_o) == '0) |=> irq_n_o); // R7

    AST_UNMASKED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~pmask_o) != '0) |=> !irq_n_o); // R7

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned           NUM_GROUPS     = DEF_NUM_GROUPS,
    parameter int unsigned           EVT_W          = DEF_EVT_W,
    parameter int unsigned           ADDR_W         = DEF_ADDR_W,
    parameter int unsigned           DATA_W         = DEF_DATA_W,
    parameter logic [ADDR_W-1:0]     PRIM_STAT_ADDR = DEF_PRIM_STAT_ADDR,
    parameter logic [ADDR_W-1:0]     PRIM_MASK_ADDR = DEF_PRIM_MASK_ADDR,
    parameter logic [ADDR_W-1:0]     SEC_STAT_BASE  = DEF_SEC_STAT_BASE,
    parameter logic [ADDR_W-1:0]     SEC_MASK_BASE  = DEF_SEC_MASK_BASE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*EVT_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        irq_n
);

    localparam int unsigned LOW_UNUSED = DATA_W - NUM_GROUPS;

    logic [EVT_W-1:0]      sec_stat [NUM_GROUPS];
    logic [EVT_W-1:0]      sec_mask [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_pend;
    logic [NUM_GROUPS-1:0] pmask;
    logic [NUM_GROUPS-1:0] pmask_wdata;
    logic                  pmask_wr;
    logic                  unused_wdata;

    assign pmask_wr     = reg_wr && (reg_addr == PRIM_MASK_ADDR);
    assign unused_wdata = ^reg_wdata;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic sel_stat_wr;
        logic sel_mask_wr;

        assign sel_stat_wr = reg_wr && (reg_addr == SEC_STAT_BASE + ADDR_W'(g));
        assign sel_mask_wr = reg_wr && (reg_addr == SEC_MASK_BASE + ADDR_W'(g));
        assign pmask_wdata[g] = reg_wdata[prim_pos(DATA_W, g)];

        irq_sec_group #(
            .EVT_W (EVT_W)
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[g*EVT_W +: EVT_W]),
            .stat_wr_i (sel_stat_wr),
            .mask_wr_i (sel_mask_wr),
            .wdata_i   (reg_wdata[EVT_W-1:0]),
            .stat_o    (sec_stat[g]),
            .mask_o    (sec_mask[g]),
            .pend_o    (grp_pend[g])
        );
    end

    irq_prim_ctrl #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_prim (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (grp_pend),
        .mask_wr_i    (pmask_wr),
        .mask_wdata_i (pmask_wdata),
        .pmask_o      (pmask),
        .irq_n_o      (irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == PRIM_STAT_ADDR) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                reg_rdata[prim_pos(DATA_W, g)] = grp_pend[g];
            end
        end else if (reg_addr == PRIM_MASK_ADDR) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                reg_rdata[prim_pos(DATA_W, g)] = pmask[g];
            end
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_addr == SEC_STAT_BASE + ADDR_W'(g)) begin
                reg_rdata[EVT_W-1:0] = sec_stat[g];
            end
            if (reg_addr == SEC_MASK_BASE + ADDR_W'(g)) begin
                reg_rdata[EVT_W-1:0] = sec_mask[g];
            end
        end
    end

    AST_PRIM_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == PRIM_STAT_ADDR) |-> (reg_rdata[LOW_UNUSED-1:0] == '0)); // R9

    AST_PRIM_VALID_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == PRIM_STAT_ADDR && pmask[0] && ((sec_stat[0] & ~sec_mask[0]) != '0))
        |-> reg_rdata[DATA_W-1]); // R6

endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

    localparam logic [15:0] A_PS = 16'h4010;
    localparam logic [15:0] A_PM = 16'h4018;
    localparam logic [15:0] A_SS = 16'h4020;
    localparam logic [15:0] A_SM = 16'h4030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] evt_i = '0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;

    logic [3:0] exp_stat [7];
    logic [3:0] exp_smask [7];
    logic [6:0] exp_pmask;

    always #5 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    function automatic logic [15:0] prim_word();
        logic [15:0] w = '0;
        for (int g = 0; g < 7; g++) begin
            if ((exp_stat[g] & ~exp_smask[g]) != 4'h0) w[15-g] = 1'b1;
        end
        return w;
    endfunction

    function automatic logic [15:0] pmask_word();
        logic [15:0] w = '0;
        for (int g = 0; g < 7; g++) w[15-g] = exp_pmask[g];
        return w;
    endfunction

    function automatic logic exp_irq_n();
        logic [15:0] p = prim_word();
        logic any = 1'b0;
        for (int g = 0; g < 7; g++) begin
            if (p[15-g] && !exp_pmask[g]) any = 1'b1;
        end
        return ~any;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == A_PM) begin
            for (int g = 0; g < 7; g++) exp_pmask[g] = d[15-g];
        end
        for (int g = 0; g < 7; g++) begin
            if (a == A_SS + 16'(g)) exp_stat[g] = exp_stat[g] & ~d[3:0];
            if (a == A_SM + 16'(g)) exp_smask[g] = d[3:0];
        end
    endtask

    task automatic pulse(input int g, input int b);
        @(negedge clk);
        evt_i[g*4+b] = 1'b1;
        @(negedge clk);
        evt_i[g*4+b] = 1'b0;
        exp_stat[g][b] = 1'b1;
    endtask

    // Waits one idle cycle so the registered irq_n has settled, then compares everything.
    task automatic check_all(input string ctx);
        logic [15:0] v;
        @(negedge clk);
        chk({"R7 irq_n ", ctx}, {15'b0, irq_n}, {15'b0, exp_irq_n()});
        for (int g = 0; g < 7; g++) begin
            rd(A_SS + 16'(g), v);
            chk({"R1 secondary status ", ctx}, v, {12'b0, exp_stat[g]});
            rd(A_SM + 16'(g), v);
            chk({"R8 secondary mask ", ctx}, v, {12'b0, exp_smask[g]});
        end
        rd(A_PS, v);
        chk({"R4 primary status ", ctx}, v, prim_word());
        rd(A_PM, v);
        chk({"R8 primary mask ", ctx}, v, pmask_word());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int g = 0; g < 7; g++) begin
            exp_stat[g]  = 4'h0;
            exp_smask[g] = 4'hF;
        end
        exp_pmask = 7'h7F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        check_all("R8 reset");
        chk("R8 irq_n after reset", {15'b0, irq_n}, 16'h0001);

        for (int g = 0; g < 7; g++) begin
            wr(A_SM + 16'(g), 16'h0000);
            for (int b = 0; b < 4; b++) begin
                pulse(g, b);
                check_all("R1 R4 R6 edge capture, primary masked");
            end
            // R7: open this primary
            wr(A_PM, pmask_word() & ~(16'h1 << (15 - g)));
            check_all("R7 primary unmasked");
            // R5: masking all secondaries drops the primary, status stays
            wr(A_SM + 16'(g), 16'h000F);
            check_all("R5 secondaries masked");
            wr(A_SM + 16'(g), 16'h0000);
            // R2: writing zeros changes nothing
            wr(A_SS + 16'(g), 16'h0000);
            check_all("R2 write zero");
            for (int b = 0; b < 4; b++) begin
                wr(A_SS + 16'(g), 16'h1 << b);
                check_all("R2 R5 clear one bit");
            end
            wr(A_PM, 16'hFE00);
        end

        // R7: two primaries pending, mask them one at a time
        pulse(0, 0);
        pulse(3, 2);
        wr(A_PM, 16'hFE00 & ~16'h8000 & ~16'h1000);
        check_all("R7 two open");
        wr(A_PM, 16'hFE00 & ~16'h1000);
        check_all("R7 one open");
        chk("R7 irq low one open", {15'b0, irq_n}, 16'h0000);
        wr(A_PM, 16'hFE00);
        check_all("R6 R7 all masked");
        rd(A_PS, v);
        chk("R6 primary reads while masked", v, 16'h9000);
        wr(A_SS + 16'd0, 16'h000F);
        wr(A_SS + 16'd3, 16'h000F);

        // R1: event held high across a clear does not re-set
        @(negedge clk);
        evt_i[2*4+1] = 1'b1;
        @(negedge clk);
        exp_stat[2][1] = 1'b1;
        wr(A_SS + 16'd2, 16'h0002);
        check_all("R1 held event");
        rd(A_SS + 16'd2, v);
        chk("R1 held level no re-set", v, 16'h0000);
        evt_i[2*4+1] = 1'b0;

        // R3: edge in the same cycle as its clear wins; other cleared bit clears
        pulse(5, 0);
        @(negedge clk);
        evt_i[5*4+3] = 1'b1;
        reg_addr  = A_SS + 16'd5;
        reg_wdata = 16'h0009;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        evt_i[5*4+3] = 1'b0;
        exp_stat[5] = 4'h8;
        check_all("R3 collision");
        rd(A_SS + 16'd5, v);
        chk("R3 event beats clear", v, 16'h0008);
        wr(A_SS + 16'd5, 16'h0008);

        // R9: map edges
        pulse(4, 1);
        wr(A_PS, 16'hFFFF);
        rd(A_PS, v);
        chk("R9 primary status read-only", v, 16'h0800);
        wr(A_SS + 16'd4, 16'hFFF0);
        rd(A_SS + 16'd4, v);
        chk("R9 upper write bits ignored", v, 16'h0002);
        wr(A_SM + 16'd6, 16'hFFF5);
        rd(A_SM + 16'd6, v);
        chk("R9 secondary mask field", v, 16'h0005);
        wr(A_PM, 16'h01FF);
        rd(A_PM, v);
        chk("R9 primary mask field", v, 16'h0000);
        check_all("R9 all primaries open");
        wr(A_PM, 16'hFFFF);
        rd(A_PM, v);
        chk("R9 primary mask low bits", v, 16'hFE00);
        rd(16'h4011, v);
        chk("R9 unmapped 4011", v, 16'h0000);
        rd(16'h4027, v);
        chk("R9 unmapped 4027", v, 16'h0000);
        rd(16'h0000, v);
        chk("R9 unmapped 0000", v, 16'h0000);
        check_all("final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule